// File: doc/BRIEF.md
# Multicycle Shared-Memory Datapath

This block is the 32-bit datapath of a small multicycle load/store processor. Each instruction runs as a series of short steps. In every step one major resource does the work: the memory, the register file or the ALU. A single memory array holds both the program and the data. A single ALU does the arithmetic for instructions, and it also adds 4 to the PC and computes branch targets. Values that pass from one step to the next sit in internal registers: the instruction register, the memory data register, the two operand latches and the ALU output register.

An external sequencer drives every strobe and mux select on every cycle. The datapath returns the opcode and function fields of the held instruction, and a flag that is high when the two operand latches match. The sequencer uses these to choose its next step. A word-wide image port writes the program and data into the memory array before and between instructions.

Top module: `mc_datapath`

## Requirements
- R1: After reset, `pc_q`, the instruction register and all registers in the register file are zero. The bench therefore sees `opcode_o`=0, `funct_o`=0 and `equal_o`=1.
- R2: The instruction register loads the memory read data on a clock edge only when `ir_write_i`=1. Otherwise it holds its value. `opcode_o` is instruction bits 31:26 and `funct_o` is bits 5:0. Register fields are rs = bits 25:21, rt = bits 20:16 and rd = bits 15:11. The immediate is bits 15:0.
- R3: The PC loads on an edge when `pc_write_i`=1. `pc_src_i`=0 loads the ALU result of that cycle. `pc_src_i`=1 loads the ALU output register.
- R4: When `pc_write_cond_i`=1 and `pc_write_i`=0, the PC loads only if the two operand latches are equal.
- R5: The ALU first operand is the PC when `alu_a_sel_i`=0 and the operand latch A when it is 1.
- R6: The ALU second operand depends on `alu_b_sel_i`: 0 selects latch B, 1 selects the constant 4, 2 selects the extended immediate, and 3 selects the extended immediate shifted left by two.
- R7: `ext_sign_i`=1 sign-extends the 16-bit immediate. `ext_sign_i`=0 zero-extends it.
- R8: `alu_ctl_i` picks the ALU function: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 nor, 6 signed less-than (result 1 or 0), 7 unsigned less-than.
- R9: A register write, enabled by `reg_write_i`, goes to rd when `dst_sel_i`=1 and to rt when it is 0. The data is the ALU output register when `wb_sel_i`=0 and the memory data register when it is 1. Register 0 always reads as zero, and writes to it are ignored.
- R10: Operand latches A and B capture the register-file values for rs and rt on every edge. `equal_o` is high exactly when A equals B.
- R11: The memory is word-addressed by address bits 2 and up. The address is the PC when `addr_sel_i`=0 and the ALU output register when it is 1. A store of latch B happens on the edge where `mem_write_i`=1. Read data is combinational while `mem_read_i`=1 and zero otherwise. The memory data register and the ALU output register load on every edge.
- R12: `img_we_i`=1 writes `img_data_i` to word `img_addr_i` on the edge. When it coincides with a store, the image write takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_write_i | input | 1 | Unconditional PC load |
| pc_write_cond_i | input | 1 | PC load when operands are equal |
| pc_src_i | input | 1 | PC source: 0 ALU result, 1 ALU output register |
| addr_sel_i | input | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_read_i | input | 1 | Memory read enable |
| mem_write_i | input | 1 | Memory store enable |
| ir_write_i | input | 1 | Instruction register load |
| dst_sel_i | input | 1 | Write register: 0 rt, 1 rd |
| wb_sel_i | input | 1 | Write data: 0 ALU output, 1 memory data register |
| reg_write_i | input | 1 | Register file write enable |
| alu_a_sel_i | input | 1 | ALU operand 1: 0 PC, 1 latch A |
| alu_b_sel_i | input | 2 | ALU operand 2 select |
| ext_sign_i | input | 1 | 1 sign-extend, 0 zero-extend |
| alu_ctl_i | input | 3 | ALU function |
| img_we_i | input | 1 | Image write enable |
| img_addr_i | input | 9 | Image word index |
| img_data_i | input | 32 | Image write data |
| opcode_o | output | 6 | Instruction bits 31:26 |
| funct_o | output | 6 | Instruction bits 5:0 |
| equal_o | output | 1 | Operand latches equal |

## Verification
The assertions assume that the sequencer never raises `pc_write_i` and `pc_write_cond_i` together with conflicting sources, and that reset is held long enough to clear every register. The bench drives only the step sequences a real controller would issue: fetch, decode, then execute, memory and write-back steps for each instruction class. Every step is separated by full cycles, and image writes happen in otherwise idle cycles, with one exception: a deliberate collision with a store. The PC is brought back to zero with a taken branch before the program area would run into the data words.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned RAW  = 5;
  localparam int unsigned NREG = 1 << RAW;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_NOR  = 3'd5,
    ALU_SLT  = 3'd6,
    ALU_SLTU = 3'd7
  } alu_ctl_e;

  typedef enum logic [1:0] {
    SRCB_REG   = 2'd0,
    SRCB_FOUR  = 2'd1,
    SRCB_IMM   = 2'd2,
    SRCB_IMMSH = 2'd3
  } srcb_e;
endpackage

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_ctl_e        ctl_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    unique case (ctl_i)
      ALU_ADD:  y_o = a_i + b_i;
      ALU_SUB:  y_o = a_i - b_i;
      ALU_AND:  y_o = a_i & b_i;
      ALU_OR:   y_o = a_i | b_i;
      ALU_XOR:  y_o = a_i ^ b_i;
      ALU_NOR:  y_o = ~(a_i | b_i);
      ALU_SLT:  y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      ALU_SLTU: y_o = {{(XLEN-1){1'b0}}, a_i < b_i};
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile import mc_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RAW-1:0]  ra_i,
  input  logic [RAW-1:0]  rb_i,
  output logic [XLEN-1:0] da_o,
  output logic [XLEN-1:0] db_o,
  input  logic            we_i,
  input  logic [RAW-1:0]  wa_i,
  input  logic [XLEN-1:0] wd_i
);
  // entry 0 has no storage; it reads as zero
  logic [XLEN-1:0] regs_q [1:NREG-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign da_o = (ra_i == '0) ? '0 : regs_q[ra_i];
  assign db_o = (rb_i == '0) ? '0 : regs_q[rb_i];
endmodule

// File: rtl/mc_memory.sv
module mc_memory import mc_pkg::*; #(
  parameter int unsigned WORDS = 512,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic            clk_i,
  input  logic            img_we_i,
  input  logic [AW-1:0]   img_idx_i,
  input  logic [XLEN-1:0] img_data_i,
  input  logic            we_i,
  input  logic            re_i,
  input  logic [AW-1:0]   idx_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (img_we_i)  mem_q[img_idx_i] <= img_data_i;
    else if (we_i) mem_q[idx_i]     <= wdata_i;
  end

  assign rdata_o = re_i ? mem_q[idx_i] : '0;
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath import mc_pkg::*; #(
  parameter int unsigned MEM_WORDS = 512,
  localparam int unsigned MEM_AW   = $clog2(MEM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pc_write_i,
  input  logic              pc_write_cond_i,
  input  logic              pc_src_i,
  input  logic              addr_sel_i,
  input  logic              mem_read_i,
  input  logic              mem_write_i,
  input  logic              ir_write_i,
  input  logic              dst_sel_i,
  input  logic              wb_sel_i,
  input  logic              reg_write_i,
  input  logic              alu_a_sel_i,
  input  logic [1:0]        alu_b_sel_i,
  input  logic              ext_sign_i,
  input  logic [2:0]        alu_ctl_i,
  input  logic              img_we_i,
  input  logic [MEM_AW-1:0] img_addr_i,
  input  logic [XLEN-1:0]   img_data_i,
  output logic [5:0]        opcode_o,
  output logic [5:0]        funct_o,
  output logic              equal_o
);
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
  logic [XLEN-1:0] rf_da, rf_db, rf_wd, mem_rdata, mem_addr;
  logic [XLEN-1:0] ext_imm, src_a, src_b, alu_y, pc_next;
  logic [RAW-1:0]  rs, rt, rd, rf_wa;
  logic [15:0]     imm;
  logic            pc_load;

  assign rs  = ir_q[25:21];
  assign rt  = ir_q[20:16];
  assign rd  = ir_q[15:11];
  assign imm = ir_q[15:0];

  assign ext_imm = ext_sign_i ? {{(XLEN-16){imm[15]}}, imm} : {{(XLEN-16){1'b0}}, imm};
  assign src_a   = alu_a_sel_i ? a_q : pc_q;

  always_comb begin
    unique case (srcb_e'(alu_b_sel_i))
      SRCB_REG:   src_b = b_q;
      SRCB_FOUR:  src_b = XLEN'(4);
      SRCB_IMM:   src_b = ext_imm;
      SRCB_IMMSH: src_b = {ext_imm[XLEN-3:0], 2'b00};
      default:    src_b = b_q;
    endcase
  end

  mc_alu u_alu (
    .a_i  (src_a),
    .b_i  (src_b),
    .ctl_i(alu_ctl_e'(alu_ctl_i)),
    .y_o  (alu_y)
  );

  assign rf_wa = dst_sel_i ? rd : rt;
  assign rf_wd = wb_sel_i ? mdr_q : alu_out_q;

  mc_regfile u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (rs),
    .rb_i  (rt),
    .da_o  (rf_da),
    .db_o  (rf_db),
    .we_i  (reg_write_i),
    .wa_i  (rf_wa),
    .wd_i  (rf_wd)
  );

  assign mem_addr = addr_sel_i ? alu_out_q : pc_q;

  mc_memory #(.WORDS(MEM_WORDS)) u_mem (
    .clk_i     (clk_i),
    .img_we_i  (img_we_i),
    .img_idx_i (img_addr_i),
    .img_data_i(img_data_i),
    .we_i      (mem_write_i),
    .re_i      (mem_read_i),
    .idx_i     (mem_addr[MEM_AW+1:2]),
    .wdata_i   (b_q),
    .rdata_o   (mem_rdata)
  );

  assign equal_o = (a_q == b_q);
  assign pc_load = pc_write_i | (pc_write_cond_i & equal_o);
  assign pc_next = pc_src_i ? alu_out_q : alu_y;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      ir_q      <= '0;
      mdr_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
    end else begin
      if (pc_load)    pc_q <= pc_next;
      if (ir_write_i) ir_q <= mem_rdata;
      mdr_q     <= mem_rdata;
      a_q       <= rf_da;
      b_q       <= rf_db;
      alu_out_q <= alu_y;
    end
  end

  assign opcode_o = ir_q[31:26];
  assign funct_o  = ir_q[5:0];
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk import mc_pkg::*; (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ir_write_i,
  input logic            pc_write_i,
  input logic            pc_write_cond_i,
  input logic            pc_src_i,
  input logic            mem_read_i,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] ir_q,
  input logic [XLEN-1:0] mdr_q,
  input logic [XLEN-1:0] a_q,
  input logic [XLEN-1:0] b_q,
  input logic [XLEN-1:0] alu_out_q
);
  assert_ir_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_write_i |=> $stable(ir_q));

  assert_pc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_write_i && !(pc_write_cond_i && a_q == b_q)) |=> $stable(pc_q));

  assert_pc_cond_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_write_cond_i && !pc_write_i && pc_src_i && a_q == b_q) |=> (pc_q == $past(alu_out_q)));

  assert_zero_reg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_q[25:21] == '0) |=> (a_q == '0));

  assert_mdr_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_read_i |=> (mdr_q == '0));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ir_write_i     (ir_write_i),
  .pc_write_i     (pc_write_i),
  .pc_write_cond_i(pc_write_cond_i),
  .pc_src_i       (pc_src_i),
  .mem_read_i     (mem_read_i),
  .pc_q           (pc_q),
  .ir_q           (ir_q),
  .mdr_q          (mdr_q),
  .a_q            (a_q),
  .b_q            (b_q),
  .alu_out_q      (alu_out_q)
);

// File: tb/mc_datapath_test.sv
`timescale 1ns/1ps
module mc_datapath_test;
  localparam int MEM_AW = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic pc_write, pc_write_cond, pc_src, addr_sel, mem_read, mem_write, ir_write;
  logic dst_sel, wb_sel, reg_write, alu_a_sel, ext_sign, img_we;
  logic [1:0] alu_b_sel;
  logic [2:0] alu_ctl;
  logic [MEM_AW-1:0] img_addr;
  logic [31:0] img_data;
  logic [5:0] opcode, funct;
  logic equal;

  mc_datapath uut (
    .clk_i(clk), .rst_ni(rst_n), .pc_write_i(pc_write), .pc_write_cond_i(pc_write_cond),
    .pc_src_i(pc_src), .addr_sel_i(addr_sel), .mem_read_i(mem_read), .mem_write_i(mem_write),
    .ir_write_i(ir_write), .dst_sel_i(dst_sel), .wb_sel_i(wb_sel), .reg_write_i(reg_write),
    .alu_a_sel_i(alu_a_sel), .alu_b_sel_i(alu_b_sel), .ext_sign_i(ext_sign), .alu_ctl_i(alu_ctl),
    .img_we_i(img_we), .img_addr_i(img_addr), .img_data_i(img_data),
    .opcode_o(opcode), .funct_o(funct), .equal_o(equal)
  );

  logic [31:0] regs_m [32];
  logic [31:0] mem_m [512];
  logic [31:0] pc_m;
  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    pc_write = 0; pc_write_cond = 0; pc_src = 0; addr_sel = 0; mem_read = 0; mem_write = 0;
    ir_write = 0; dst_sel = 0; wb_sel = 0; reg_write = 0; alu_a_sel = 0; alu_b_sel = 0;
    ext_sign = 0; alu_ctl = 0; img_we = 0; img_addr = 0; img_data = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] alu_ref(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return ~(a | b);
      3'd6: return {31'd0, $signed(a) < $signed(b)};
      default: return {31'd0, a < b};
    endcase
  endfunction

  task automatic boot(input logic [31:0] byte_addr, input logic [31:0] data);
    clr();
    img_we = 1; img_addr = byte_addr[MEM_AW+1:2]; img_data = data;
    mem_m[byte_addr[MEM_AW+1:2]] = data;
    tick();
    clr();
  endtask

  task automatic fetch_nb(input logic [31:0] w, input string req);
    clr();
    mem_read = 1; ir_write = 1; alu_b_sel = 2'd1; alu_ctl = 3'd0; pc_write = 1;
    tick();
    clr();
    chk(opcode === w[31:26], req, {26'd0, opcode}, {26'd0, w[31:26]});
    chk(funct === w[5:0], req, {26'd0, funct}, {26'd0, w[5:0]});
    pc_m = pc_m + 4;
  endtask

  task automatic fetch_decode(input logic [31:0] w);
    boot(pc_m, w);
    fetch_nb(w, "R2 R3 fetch");
    alu_b_sel = 2'd3; ext_sign = 1; alu_ctl = 3'd0;
    tick();
    clr();
  endtask

  task automatic rtype(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd, input logic [2:0] c);
    fetch_decode({6'd0, rs, rt, rd, 5'd0, 3'd0, c});
    alu_a_sel = 1; alu_b_sel = 2'd0; alu_ctl = c;
    tick();
    clr();
    dst_sel = 1; reg_write = 1;
    tick();
    clr();
    if (rd != 0) regs_m[rd] = alu_ref(c, regs_m[rs], regs_m[rt]);
  endtask

  task automatic ori(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    fetch_decode({6'h0d, rs, rt, imm});
    alu_a_sel = 1; alu_b_sel = 2'd2; ext_sign = 0; alu_ctl = 3'd3;
    tick();
    clr();
    reg_write = 1;
    tick();
    clr();
    if (rt != 0) regs_m[rt] = regs_m[rs] | {16'd0, imm};
  endtask

  task automatic lw(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    logic [31:0] ea;
    fetch_decode({6'h23, rs, rt, imm});
    alu_a_sel = 1; alu_b_sel = 2'd2; ext_sign = 1; alu_ctl = 3'd0;
    tick();
    clr();
    addr_sel = 1; mem_read = 1;
    tick();
    clr();
    wb_sel = 1; reg_write = 1;
    tick();
    clr();
    ea = regs_m[rs] + sext(imm);
    if (rt != 0) regs_m[rt] = mem_m[ea[MEM_AW+1:2]];
  endtask

  task automatic sw(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm,
                    input bit clash, input logic [31:0] clash_data);
    logic [31:0] ea;
    fetch_decode({6'h2b, rs, rt, imm});
    alu_a_sel = 1; alu_b_sel = 2'd2; ext_sign = 1; alu_ctl = 3'd0;
    tick();
    clr();
    ea = regs_m[rs] + sext(imm);
    addr_sel = 1; mem_write = 1;
    if (clash) begin
      img_we = 1; img_addr = ea[MEM_AW+1:2]; img_data = clash_data;
    end
    tick();
    clr();
    mem_m[ea[MEM_AW+1:2]] = clash ? clash_data : regs_m[rt];
  endtask

  task automatic beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    fetch_decode({6'h04, rs, rt, imm});
    alu_a_sel = 1; alu_b_sel = 2'd0; alu_ctl = 3'd1; pc_write_cond = 1; pc_src = 1;
    tick();
    clr();
    if (regs_m[rs] == regs_m[rt]) pc_m = pc_m + {sext(imm)[29:0], 2'b00};
  endtask

  task automatic probe(input logic [4:0] ra, input logic [4:0] rb, input bit exp, input string req);
    fetch_decode({6'd0, ra, rb, 5'd0, 5'd0, 6'd0});
    chk(equal === exp, req, {31'd0, equal}, {31'd0, exp});
  endtask

  task automatic check_reg(input logic [4:0] r, input string req);
    boot(32'h7F0, regs_m[r]);
    lw(5'd0, 5'd30, 16'h07F0);
    probe(r, 5'd30, 1'b1, req);
  endtask

  task automatic rewind();
    int off;
    if (pc_m >= 32'h500) begin
      off = -int'((pc_m + 4) >> 2);
      beq(5'd0, 5'd0, off[15:0]);
      chk(pc_m == 0, "R4 rewind model", pc_m, 0);
    end
  endtask

  task automatic branch_test(input logic [4:0] rs, input logic [4:0] rt, input string req);
    logic [31:0] fall_w, tgt_w;
    fall_w = {6'h01, 20'h12345, 6'h11};
    tgt_w  = {6'h3E, 20'h54321, 6'h2A};
    boot(pc_m + 4, fall_w);
    boot(pc_m + 16, tgt_w);
    beq(rs, rt, 16'd3);
    fetch_nb((regs_m[rs] == regs_m[rt]) ? tgt_w : fall_w, req);
  endtask

  initial begin : watchdog
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] vals [6];
    logic [5:0] held_op;
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h1234_5678;
    for (int i = 0; i < 32; i++) regs_m[i] = 0;
    for (int i = 0; i < 512; i++) mem_m[i] = 0;
    pc_m = 0;
    clr();
    rst_n = 0;
    repeat (3) tick();
    chk(opcode === 6'd0, "R1 reset opcode", {26'd0, opcode}, 0);
    chk(funct === 6'd0, "R1 reset funct", {26'd0, funct}, 0);
    chk(equal === 1'b1, "R1 reset equal", {31'd0, equal}, 1);
    rst_n = 1;
    tick();

    // zero-extended immediate, destination rt (bits 15:11 of imm name r16)
    ori(5'd0, 5'd5, 16'h8001);
    check_reg(5'd5, "R7 zero-extend");
    check_reg(5'd16, "R9 rt destination");

    // ALU sweep over operand pairs and every function
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        boot(32'h700, vals[i]);
        boot(32'h704, vals[j]);
        lw(5'd0, 5'd1, 16'h0700);
        lw(5'd0, 5'd2, 16'h0704);
        probe(5'd1, 5'd2, vals[i] == vals[j], "R10 equal flag");
        for (int c = 0; c < 8; c++) begin
          rtype(5'd1, 5'd2, 5'd3, 3'(c));
          check_reg(5'd3, "R5 R6 R8 alu result");
          rewind();
        end
      end
    end

    // write to register 0 ignored
    rtype(5'd1, 5'd1, 5'd0, 3'd0);
    check_reg(5'd0, "R9 zero register");

    // sign-extended negative offset
    ori(5'd0, 5'd6, 16'h0800);
    boot(32'h7FC, 32'hCAFE_F00D);
    lw(5'd6, 5'd7, 16'hFFFC);
    check_reg(5'd7, "R7 sign-extend");
    rewind();

    // store then reload
    ori(5'd0, 5'd8, 16'h1357);
    sw(5'd0, 5'd8, 16'h0710, 1'b0, 32'h0);
    lw(5'd0, 5'd9, 16'h0710);
    check_reg(5'd9, "R11 store reload");

    // image write collides with store
    sw(5'd0, 5'd8, 16'h0714, 1'b1, 32'h5A5A_0F0F);
    lw(5'd0, 5'd10, 16'h0714);
    check_reg(5'd10, "R12 image priority");
    rewind();

    // conditional PC load
    ori(5'd0, 5'd11, 16'd5);
    ori(5'd0, 5'd12, 16'd5);
    ori(5'd0, 5'd13, 16'd6);
    branch_test(5'd11, 5'd12, "R4 taken");
    branch_test(5'd11, 5'd13, "R4 not taken");
    rewind();

    // IR holds without ir_write; read data gated by mem_read
    held_op = opcode;
    clr(); mem_read = 1;
    tick();
    clr();
    chk(opcode === held_op, "R2 ir hold", {26'd0, opcode}, {26'd0, held_op});
    ir_write = 1;
    tick();
    clr();
    chk(opcode === 6'd0 && funct === 6'd0, "R11 read gating", {20'd0, opcode, funct}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule